// File: doc/BRIEF.md
# Memory-Card Slot Status Registers

This block gives software a small register window onto a removable memory-card slot. It has a word-addressed register bus with a one-cycle write strobe and a combinational read port. Two words return constants: an identity code and a decode-configuration code.

A third word is the live slot status. It mixes two kinds of bit:
- a level bit that mirrors the card write-protect switch;
- a sticky bit that records a card insertion and stays set until software clears it by writing a 1 to it.

The sticky bit drives the interrupt output directly. Both slot inputs are asynchronous to the bus clock, so each passes through a two-flop synchroniser before the register logic uses it.

Top module: `card_slot_regs`

## Requirements
- R1: After reset the status word (word 2) reads 0 and `card_irq` is 0.
- R2: Word 0 reads the identity constant 0x41034003, and word 3 reads the decode constant 0x00000011, whatever was written before.
- R3: Word 1 reads 0, and a write to word 1 changes no register.
- R4: Bit 0 of word 2 equals `wp_level` delayed by two clock edges, because the input is synchronised.
- R5: Bit 3 of word 2 is the sticky insertion flag. It becomes 1 three clock edges after `card_level` rises: two synchroniser stages and then the flag register. It stays 1 after `card_level` falls.
- R6: A write to word 2 with bit 3 of the write data set clears the sticky flag on that clock edge. A write to word 2 with bit 3 clear has no effect, and bit 0 cannot be written.
- R7: If the synchronised card level is still high on the edge where the clear is written, the flag stays 1. The set takes priority over the clear.
- R8: `card_irq` equals bit 3 of word 2 at all times.
- R9: Words 4 and above read 0, writes to them change no register, and bits 1, 2 and 4 to 31 of word 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Word index of the access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| wp_level | input | 1 | Write-protect switch level, asynchronous |
| card_level | input | 1 | Card-present level, asynchronous |
| card_irq | output | 1 | Card-insertion interrupt, equal to the sticky flag |

## Verification
The hardest case to reach is a clear that lands while the synchronised card level is still high. The card input must rise at least two edges before the write, so that the late synchroniser stage is already 1 when the clear strobe arrives. A directed sequence sets this up: it raises the card input, waits, writes the clear while the input is held high, and then repeats the clear after the input has dropped and drained through the synchroniser. Random traffic with a fixed seed then mixes input toggles with writes to every offset, and a bench model that tracks the two-stage delay checks each read and the interrupt on every cycle.

// File: rtl/card_slot_regs.sv
module card_slot_regs #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] ID_CODE = 32'h4103_4003,
  parameter logic [DATA_W-1:0] DECODE_CODE = 32'h0000_0011,
  parameter int WP_BIT = 0,
  parameter int CARD_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              wp_level,
  input  logic              card_level,
  output logic              card_irq
);
  localparam logic [ADDR_W-1:0] A_ID     = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PROG   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DECODE = ADDR_W'(3);

  logic [1:0] wp_sync, card_sync;
  logic       inserted;
  logic       clr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_sync   <= '0;
      card_sync <= '0;
    end else begin
      wp_sync   <= {wp_sync[0], wp_level};
      card_sync <= {card_sync[0], card_level};
    end
  end

  assign clr_req = reg_wr && (reg_addr == A_STATUS) && reg_wdata[CARD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inserted <= 1'b0;
    else        inserted <= card_sync[1] | (inserted & ~clr_req);
  end

  assign card_irq = inserted;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ID:     reg_rdata = ID_CODE;
      A_PROG:   reg_rdata = '0;
      A_STATUS: begin
        reg_rdata[WP_BIT]   = wp_sync[1];
        reg_rdata[CARD_BIT] = inserted;
      end
      A_DECODE: reg_rdata = DECODE_CODE;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/card_slot_regs_chk.sv
module card_slot_regs_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              card_irq,
  input logic [1:0]        card_sync
);
  logic clr;
  assign clr = reg_wr && reg_addr == ADDR_W'(2) && reg_wdata[3];

  p_id_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == ADDR_W'(0) |-> reg_rdata == 32'h4103_4003);

  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    card_sync[1] |=> card_irq);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    card_irq && !clr |=> card_irq);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !card_sync[1] |=> !card_irq);

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !card_irq && !card_sync[1] |=> !card_irq);

  p_irq_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == ADDR_W'(2) |-> reg_rdata[3] == card_irq);

  p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr >= ADDR_W'(4) |-> reg_rdata == '0);
endmodule

bind card_slot_regs card_slot_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_irq(card_irq),
  .card_sync(card_sync)
);

// File: tb/card_slot_regs_tb.sv
module card_slot_regs_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  reg_addr = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        wp_level = 0, card_level = 0;
  logic        card_irq;

  int total = 0, bad = 0;
  logic w1 = 0, w2 = 0, c1 = 0, c2 = 0, stk = 0;

  always #10 clk = ~clk;

  card_slot_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wp_level(wp_level),
    .card_level(card_level), .card_irq(card_irq)
  );

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0: return 32'h4103_4003;
      4'd2: return {28'd0, stk, 2'b00, w2};
      4'd3: return 32'h0000_0011;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] a, input logic wr, input logic [31:0] d,
                      input logic wp, input logic cd, input string req);
    logic clr;
    reg_addr = a; reg_wr = wr; reg_wdata = d; wp_level = wp; card_level = cd;
    #1;
    check(req, reg_rdata, exp_read(a));
    check("R8", {31'd0, card_irq}, {31'd0, stk});
    clr = wr && a == 4'd2 && d[3];
    @(posedge clk);
    stk = c2 | (stk & ~clr);
    c2 = c1; c1 = cd;
    w2 = w1; w1 = wp;
    @(negedge clk);
  endtask

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    #5;
    check("R1", {31'd0, card_irq}, 32'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    step(4'd2, 0, 0, 0, 0, "R1");
    step(4'd0, 1, 32'hFFFF_FFFF, 0, 0, "R2");
    step(4'd0, 0, 0, 0, 0, "R2");
    step(4'd3, 1, 32'h0, 0, 0, "R2");
    step(4'd3, 0, 0, 0, 0, "R2");
    // R4: write-protect appears after two edges
    step(4'd2, 0, 0, 1, 0, "R4");
    step(4'd2, 0, 0, 1, 0, "R4");
    step(4'd2, 0, 0, 1, 0, "R4");
    check("R4", reg_rdata & 32'h1, 32'h1);
    // R5: insertion latches and holds after card drops
    step(4'd2, 0, 0, 1, 1, "R5");
    step(4'd2, 0, 0, 1, 0, "R5");
    step(4'd2, 0, 0, 1, 0, "R5");
    step(4'd2, 0, 0, 1, 0, "R5");
    check("R5", {31'd0, card_irq}, 32'd1);
    for (int i = 0; i < 3; i++) step(4'd2, 0, 0, 0, 0, "R5");
    // R3, R9: writes elsewhere do not clear the flag
    step(4'd1, 1, 32'hFFFF_FFFF, 0, 0, "R3");
    step(4'd1, 0, 0, 0, 0, "R3");
    step(4'd7, 1, 32'hFFFF_FFFF, 0, 0, "R9");
    step(4'd15, 0, 0, 0, 0, "R9");
    step(4'd2, 0, 0, 0, 0, "R3");
    check("R3", {31'd0, card_irq}, 32'd1);
    // R6: write without bit 3 has no effect, then a clear
    step(4'd2, 1, 32'hFFFF_FFF7, 0, 0, "R6");
    step(4'd2, 1, 32'h8, 0, 0, "R6");
    step(4'd2, 0, 0, 0, 0, "R6");
    check("R6", {31'd0, card_irq}, 32'd0);
    // R7: the clear collides with a held card level
    step(4'd2, 0, 0, 0, 1, "R7");
    step(4'd2, 0, 0, 0, 1, "R7");
    step(4'd2, 0, 0, 0, 1, "R7");
    step(4'd2, 1, 32'h8, 0, 1, "R7");
    step(4'd2, 0, 0, 0, 0, "R7");
    check("R7", {31'd0, card_irq}, 32'd1);
    step(4'd2, 0, 0, 0, 0, "R7");
    step(4'd2, 1, 32'h8, 0, 0, "R6");
    step(4'd2, 0, 0, 0, 0, "R6");
    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a;
      logic [31:0] d;
      a = 4'($urandom_range(0, 5) == 5 ? $urandom : $urandom_range(0, 3));
      d = $urandom;
      step(a, 1'($urandom), d, 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 7) == 0), "R9");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule